// File: doc/BRIEF.md
# Shifted-Register OR-with-Complement Execute Unit

This unit decodes and executes one 32-bit instruction word of the logical OR-with-complement family that takes a shifted second operand. It checks the word against the fixed opcode bits. It pulls out the two source indices and the destination index, and it detects the one undefined encoding. It then computes the first operand ORed with the inverted, shifted second operand, either at 32-bit or at 64-bit width.

The register file sits outside the unit. The two source indices are driven out combinationally from the incoming word, and the surrounding pipeline returns the matching register values in the same cycle. Index 31 in a source field reads as zero inside the unit, whatever value is presented. When the first source index is 31, the operation becomes a plain move of the inverted, shifted operand.

A two-state control machine qualifies the registered outputs. The states are `ST_IDLE` (no result presented) and `ST_LIVE` (a result presented). The transition `IDLE->LIVE` is taken on `in_valid`. `LIVE->LIVE` is taken on back-to-back `in_valid`. `LIVE->IDLE` and `IDLE->IDLE` are taken when `in_valid` is low. Every word completes in exactly one cycle, whatever its data or shift amount.

Top module: `ornx_exec`

## Requirements
- R1: After reset, and in any cycle in which `out_valid` is low, `out_wen`, `out_undef` and `out_nomatch` are 0 and `out_result` is zero.
- R2: `out_valid` is high in the cycle after every cycle with `in_valid` high, and low otherwise, so each word has a fixed latency of one cycle whatever its operands or shift amount.
- R3: A word matches only when bits 30:29 are 01, bits 28:24 are 01010 and bit 21 is 1. A non-matching word gives `out_nomatch`=1, `out_undef`=0, `out_wen`=0 and a zero result.
- R4: A matching word with bit 31 (size) equal to 0 and bit 15 (imm6 bit 5) equal to 1 gives `out_undef`=1, `out_wen`=0, `out_nomatch`=0 and a zero result.
- R5: With size bit 1, the result is A | ~shift(B) over 64 bits. The shift amount is bits 15:10. Bits 23:22 select the shift: 00 is logical left, 01 is logical right, 10 is arithmetic right (sign fill from bit 63) and 11 is rotate right.
- R6: With size bit 0, the shift, rotate and sign fill act on B[31:0] by bits 14:10. The low 32 bits of the result are A[31:0] | ~shifted, and result bits 63:32 are zero.
- R7: When bits 9:5 (first source index) equal 31, A is taken as zero and the result is the complement of the shifted B at the operation width.
- R8: When bits 20:16 (second source index) equal 31, B is taken as zero, so a legal word yields all ones at the operation width.
- R9: A legal word has `out_wen`=1 unless bits 4:0 equal 31, in which case `out_wen`=0 and the result is still produced.
- R10: `src_a_idx` equals bits 9:5 and `src_b_idx` equals bits 20:16 of `in_word` in the same cycle. `out_rd` equals bits 4:0 of the word that was accepted in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 32 | Instruction word |
| src_a_idx | output | 5 | First source index, to the register file |
| src_b_idx | output | 5 | Second source index, to the register file |
| src_a_val | input | 64 | Value read for `src_a_idx` |
| src_b_val | input | 64 | Value read for `src_b_idx` |
| out_valid | output | 1 | Result presented this cycle |
| out_result | output | 64 | Result, zero-extended in 32-bit mode |
| out_wen | output | 1 | Write-back enable |
| out_rd | output | 5 | Destination index |
| out_undef | output | 1 | Undefined-encoding flag |
| out_nomatch | output | 1 | Word is not of this opcode |

## Verification
The assertions cover the control behaviour on every cycle. They check the one-cycle valid latency, the quiet outputs while idle, and the exclusivity of no-match, undefined and write-back. They also check that write-back never targets index 31, that rejected words give a zero result, that 32-bit results have a zero upper half, and that the destination index comes through unchanged. The correctness of the shifted arithmetic can only be shown by the bench. It sweeps every size, every shift type and every amount from 0 to 63 over several operand patterns. It also mixes in zero-register source and destination indices and non-matching words, and compares each result with a value computed arithmetically.

// File: rtl/ornx_pkg.sv
package ornx_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 5;
    localparam int IMM_W  = 6;
    localparam logic [IDX_W-1:0] ZERO_REG = 5'd31;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LIVE = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic              match;
        logic              undef;
        logic              wide;
        shift_kind_e       kind;
        logic [IMM_W-1:0]  amount;
        logic [IDX_W-1:0]  idx_a;
        logic [IDX_W-1:0]  idx_b;
        logic [IDX_W-1:0]  idx_d;
    } dec_fields_t;

endpackage

// File: rtl/ornx_decode.sv
module ornx_decode
    import ornx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_fields_t       fields
);

    logic opc_ok;
    logic fix_ok;
    logic inv_ok;

    always_comb begin
        opc_ok = (word[30:29] == 2'b01);
        fix_ok = (word[28:24] == 5'b01010);
        inv_ok = word[21];

        fields.match  = opc_ok && fix_ok && inv_ok;
        fields.wide   = word[31];
        fields.kind   = shift_kind_e'(word[23:22]);
        fields.amount = word[15:10];
        fields.idx_b  = word[20:16];
        fields.idx_a  = word[9:5];
        fields.idx_d  = word[4:0];
        // narrow form cannot encode a shift of 32 or more
        fields.undef  = fields.match && !word[31] && word[15];
    end

endmodule

// File: rtl/ornx_shifter.sv
module ornx_shifter
    import ornx_pkg::*;
#(
    parameter int W = 64,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  shift_kind_e   kind,
    output logic [W-1:0]  dout
);

    // logarithmic barrel: one fixed stage per amount bit, so the
    // path depth does not depend on the data or on the amount
    always_comb begin
        logic [W-1:0] v;
        v = din;
        for (int k = 0; k < AW; k++) begin
            if (amt[k]) begin
                unique case (kind)
                    SH_LSL: v = v << (1 << k);
                    SH_LSR: v = v >> (1 << k);
                    SH_ASR: v = W'($signed(v) >>> (1 << k));
                    SH_ROR: v = (v >> (1 << k)) | (v << (W - (1 << k)));
                    default: v = v;
                endcase
            end
        end
        dout = v;
    end

endmodule

// File: rtl/ornx_exec.sv
module ornx_exec
    import ornx_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2,
    localparam int AW_WIDE = $clog2(XLEN),
    localparam int AW_HALF = $clog2(HALF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic [IDX_W-1:0]  src_a_idx,
    output logic [IDX_W-1:0]  src_b_idx,
    input  logic [XLEN-1:0]   src_a_val,
    input  logic [XLEN-1:0]   src_b_val,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_result,
    output logic              out_wen,
    output logic [IDX_W-1:0]  out_rd,
    output logic              out_undef,
    output logic              out_nomatch
);

    dec_fields_t dec;
    ctl_state_e  state_q, state_d;

    logic [XLEN-1:0] opnd_a, opnd_b;
    logic [XLEN-1:0] sh_wide;
    logic [HALF-1:0] sh_half;
    logic [XLEN-1:0] res_wide, res_half, res_sel;
    logic            legal;
    logic            wen_d;

    ornx_decode u_decode (
        .word   (in_word),
        .fields (dec)
    );

    assign src_a_idx = dec.idx_a;
    assign src_b_idx = dec.idx_b;

    // index 31 reads as zero in either source
    always_comb begin
        opnd_a = (dec.idx_a == ZERO_REG) ? '0 : src_a_val;
        opnd_b = (dec.idx_b == ZERO_REG) ? '0 : src_b_val;
    end

    ornx_shifter #(.W(XLEN)) u_shift_wide (
        .din  (opnd_b),
        .amt  (dec.amount[AW_WIDE-1:0]),
        .kind (dec.kind),
        .dout (sh_wide)
    );

    ornx_shifter #(.W(HALF)) u_shift_half (
        .din  (opnd_b[HALF-1:0]),
        .amt  (dec.amount[AW_HALF-1:0]),
        .kind (dec.kind),
        .dout (sh_half)
    );

    always_comb begin
        res_wide = opnd_a | ~sh_wide;
        res_half = {{(XLEN-HALF){1'b0}}, opnd_a[HALF-1:0] | ~sh_half};
        res_sel  = dec.wide ? res_wide : res_half;
        legal    = dec.match && !dec.undef;
        wen_d    = legal && (dec.idx_d != ZERO_REG);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_LIVE : ST_IDLE;
            ST_LIVE: state_d = in_valid ? ST_LIVE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_result  <= '0;
            out_wen     <= 1'b0;
            out_rd      <= '0;
            out_undef   <= 1'b0;
            out_nomatch <= 1'b0;
        end else begin
            out_result  <= legal ? res_sel : '0;
            out_wen     <= wen_d;
            out_rd      <= dec.idx_d;
            out_undef   <= dec.undef;
            out_nomatch <= !dec.match;
        end
    end

    assign out_valid = (state_q == ST_LIVE);

endmodule

// File: rtl/ornx_exec_chk.sv
module ornx_exec_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     in_word,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result,
    input logic            out_wen,
    input logic [4:0]      out_rd,
    input logic            out_undef,
    input logic            out_nomatch
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_wen && !out_undef && !out_nomatch && out_result == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_nomatch_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_nomatch |-> (!out_wen && !out_undef && out_result == '0));

    assert_undef_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> (!out_wen && !out_nomatch && out_result == '0));

    assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_word[31]) |=> (out_result[XLEN-1:32] == '0));

    assert_no_write_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> (out_rd != 5'd31));

    assert_rd_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_rd == $past(in_word[4:0])));

endmodule

bind ornx_exec ornx_exec_chk #(.XLEN(XLEN)) u_ornx_exec_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_wen     (out_wen),
    .out_rd      (out_rd),
    .out_undef   (out_undef),
    .out_nomatch (out_nomatch)
);

// File: tb/test_ornx_exec.sv
module test_ornx_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [4:0]  src_a_idx, src_b_idx;
    logic [63:0] src_a_val = '0, src_b_val = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_wen;
    logic [4:0]  out_rd;
    logic        out_undef;
    logic        out_nomatch;

    int checks = 0;
    int fails  = 0;

    logic        pend = 1'b0;
    logic [63:0] e_res;
    logic        e_wen, e_undef, e_nom;
    logic [4:0]  e_rd;
    string       e_tag;

    always #2.5 clk = ~clk;

    ornx_exec i_ornx_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .src_a_val(src_a_val), .src_b_val(src_b_val),
        .out_valid(out_valid), .out_result(out_result), .out_wen(out_wen),
        .out_rd(out_rd), .out_undef(out_undef), .out_nomatch(out_nomatch)
    );

    function automatic logic [31:0] mk(input logic sf, input logic [1:0] sh,
                                       input logic [4:0] rm, input logic [5:0] imm,
                                       input logic [4:0] rn, input logic [4:0] rd);
        return {sf, 2'b01, 5'b01010, sh, 1'b1, rm, imm, rn, rd};
    endfunction

    function automatic logic [63:0] model(input logic sf, input logic [1:0] sh,
                                          input int amt, input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] s64;
        logic [31:0] s32;
        if (sf) begin
            case (sh)
                2'd0: s64 = b << amt;
                2'd1: s64 = b >> amt;
                2'd2: s64 = 64'($signed(b) >>> amt);
                default: s64 = (amt == 0) ? b : ((b >> amt) | (b << (64 - amt)));
            endcase
            return a | ~s64;
        end
        case (sh)
            2'd0: s32 = b[31:0] << amt;
            2'd1: s32 = b[31:0] >> amt;
            2'd2: s32 = 32'($signed(b[31:0]) >>> amt);
            default: s32 = (amt == 0) ? b[31:0] : ((b[31:0] >> amt) | (b[31:0] << (32 - amt)));
        endcase
        return {32'h0, a[31:0] | ~s32};
    endfunction

    task automatic step(input logic v, input logic [31:0] w,
                        input logic [63:0] a, input logic [63:0] b);
        logic        match, sf, und;
        logic [4:0]  rn, rm, rd;
        logic [63:0] ea, eb;
        @(negedge clk);
        checks++;
        if (pend) begin
            if (!out_valid || out_result !== e_res || out_wen !== e_wen ||
                out_undef !== e_undef || out_nomatch !== e_nom || out_rd !== e_rd) begin
                fails++;
                $display("FAIL %s: got v=%b res=%h wen=%b und=%b nom=%b rd=%0d exp v=1 res=%h wen=%b und=%b nom=%b rd=%0d",
                         e_tag, out_valid, out_result, out_wen, out_undef, out_nomatch, out_rd,
                         e_res, e_wen, e_undef, e_nom, e_rd);
            end
        end else if (out_valid !== 1'b0 || out_wen !== 1'b0 || out_result !== 64'h0) begin
            fails++;
            $display("FAIL R1/R2 idle: got v=%b wen=%b res=%h exp v=0 wen=0 res=0",
                     out_valid, out_wen, out_result);
        end
        in_valid  = v;
        in_word   = w;
        src_a_val = a;
        src_b_val = b;
        pend      = v;
        if (v) begin
            #1;
            checks++;
            if (src_a_idx !== w[9:5] || src_b_idx !== w[20:16]) begin
                fails++;
                $display("FAIL R10 idx: got a=%0d b=%0d exp a=%0d b=%0d",
                         src_a_idx, src_b_idx, w[9:5], w[20:16]);
            end
            match = (w[30:29] == 2'b01) && (w[28:24] == 5'b01010) && w[21];
            sf = w[31];
            rn = w[9:5]; rm = w[20:16]; rd = w[4:0];
            und = match && !sf && w[15];
            ea = (rn == 5'd31) ? 64'h0 : a;
            eb = (rm == 5'd31) ? 64'h0 : b;
            e_nom   = !match;
            e_undef = und;
            e_rd    = rd;
            e_wen   = match && !und && rd != 5'd31;
            e_res   = (match && !und) ? model(sf, w[23:22], int'(w[15:10]), ea, eb) : 64'h0;
            if (!match)            e_tag = "R3 nomatch";
            else if (und)          e_tag = "R4 undef";
            else if (rd == 5'd31)  e_tag = "R9 zero-dest";
            else if (rn == 5'd31)  e_tag = "R7 move-not";
            else if (rm == 5'd31)  e_tag = "R8 zero-b";
            else if (!sf)          e_tag = "R6 narrow";
            else                   e_tag = "R5 wide";
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] pa [3];
        logic [63:0] pb [3];
        pa[0] = 64'h0123_4567_89AB_CDEF; pb[0] = 64'h8000_0000_8000_0001;
        pa[1] = 64'h0;                   pb[1] = 64'hF0F0_1234_C3A5_5A3C;
        pa[2] = 64'h1111_0000_0000_1111; pb[2] = 64'h7FFF_FFFF_0000_FFFF;

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;  // R1 reset state
        if (out_valid !== 1'b0 || out_wen !== 1'b0 || out_undef !== 1'b0 ||
            out_nomatch !== 1'b0 || out_result !== 64'h0) begin
            fails++;
            $display("FAIL R1 reset: got v=%b wen=%b und=%b nom=%b res=%h exp all zero",
                     out_valid, out_wen, out_undef, out_nomatch, out_result);
        end
        rst_n = 1'b1;

        // full sweep of size, shift type and amount (R5, R6, R4)
        for (int sf = 0; sf < 2; sf++)
            for (int sh = 0; sh < 4; sh++)
                for (int amt = 0; amt < 64; amt++)
                    for (int p = 0; p < 3; p++) begin
                        logic [4:0] rn, rm, rd;
                        rn = (amt % 7 == 3) ? 5'd31 : 5'(1 + (amt % 29));
                        rm = (amt % 11 == 5) ? 5'd31 : 5'(2 + (amt % 23));
                        rd = (amt % 13 == 6) ? 5'd31 : 5'(3 + (amt % 17));
                        step(1'b1, mk(sf[0], sh[1:0], rm, amt[5:0], rn, rd), pa[p], pb[p]);
                        if (p == 2 && amt % 9 == 0) step(1'b0, 32'h0, 64'h0, 64'h0);
                    end

        // R7: index 31 in first source ignores a non-zero value
        step(1'b1, mk(1'b1, 2'd1, 5'd4, 6'd8, 5'd31, 5'd2), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF00);
        step(1'b1, mk(1'b0, 2'd3, 5'd4, 6'd4, 5'd31, 5'd2), 64'hFFFF_FFFF_FFFF_FFFF, 64'hF);
        // R8: index 31 in second source gives all ones
        step(1'b1, mk(1'b1, 2'd2, 5'd31, 6'd5, 5'd1, 5'd2), 64'h0, 64'h1234);
        step(1'b1, mk(1'b0, 2'd0, 5'd31, 6'd5, 5'd1, 5'd2), 64'h0, 64'h1234);
        // R3: opcode mismatches, incl. one that would otherwise be undefined
        step(1'b1, mk(1'b1, 2'd0, 5'd1, 6'd1, 5'd1, 5'd1) & ~32'h0020_0000, 64'h5, 64'h6);
        step(1'b1, mk(1'b0, 2'd0, 5'd1, 6'd33, 5'd1, 5'd1) ^ 32'h2000_0000, 64'h5, 64'h6);
        step(1'b1, mk(1'b1, 2'd3, 5'd1, 6'd1, 5'd1, 5'd1) ^ 32'h0100_0000, 64'h5, 64'h6);
        step(1'b1, 32'h0, 64'h5, 64'h6);
        // R9: zero-register destination
        step(1'b1, mk(1'b1, 2'd0, 5'd1, 6'd0, 5'd1, 5'd31), 64'h0, 64'hFF);
        step(1'b0, 32'h0, 64'h0, 64'h0);
        step(1'b0, 32'h0, 64'h0, 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule